// File: doc/BRIEF.md
# Logarithmic Gradual Dimming Sequencer

This block holds the 5-bit brightness code that drives a backlight LED current mirror and walks it toward a target, one code per step period. A register-write port, fed by a serial host interface decoder, carries four commands. The first sets the code at once. The second and third arm a ramp target and its direction, upward or downward. The fourth stores the time per step and launches the armed ramp. The code selects one of 32 entries in a logarithmic table. The table's 16-bit value, in which 0xFFFF stands for full scale, goes to the current mirror alongside the code.

A prescaler cut from the system clock produces a 10 ms time unit. The step period is a binary-weighted sum of these units. A ramp runs from wherever the code stands when the start command arrives, so the total ramp time is the step period multiplied by the number of codes crossed, which is at most 31. Inconsistent commands can never push the code outside 0x00..0x1F and never leave the sequencer stuck. Examples are an upward ramp armed with a lower target, or a downward ramp armed with a higher one.

Top module: `dimSequencer`

## Requirements
- R1: After reset the code is 0x00, the level is 0x0000 and busy is 0, and every stored register is zero. A start command issued with nothing armed therefore ends one time unit later with the code still 0x00 and busy 0.
- R2: A write with select 0x1 puts wrData[4:0] on ledCode at the write edge. wrData[7:5] has no effect. The write also abandons any running ramp, so busy is 0 from that edge on.
- R3: A write with select 0x2 arms an upward ramp to wrData[4:0], and select 0x3 arms a downward ramp to wrData[4:0]. Neither changes ledCode or a ramp already running.
- R4: A write with select 0x4 stores wrData[4:0] as the step time and raises busy at the write edge. The ramp restarts from the present code toward the armed target, and the step timing restarts from that edge.
- R5: Step-time bits 0..4 weigh 1, 2, 4, 8 and 16 time units (10, 20, 40, 80 and 160 ms). The k-th step lands exactly k × step time × UNIT_CYCLES cycles after the start edge.
- R6: Each step moves the code by exactly one toward the target. Busy falls on the edge at which the code reaches the target.
- R7: A step time of zero moves the code straight to the target one time unit after the start edge, and busy falls on that edge.
- R8: An upward ramp with target ≤ code, or a downward ramp with target ≥ code, leaves the code unchanged and drops busy at the first step time. The code never passes 0x1F or 0x00.
- R9: ledLevel equals round(65535 × 10^((code−31)/10)) within 2 LSB for codes 1..31, so each code step is a factor of 10^0.1. Code 0x00 gives 0x0000 and code 0x1F gives 0xFFFF.
- R10: Writes with any select other than 0x1..0x4 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle |
| wrSel | input | 4 | Register select of the write |
| wrData | input | 8 | Register write data |
| ledCode | output | 5 | Present brightness code |
| ledLevel | output | 16 | Logarithmic table value for ledCode, 0xFFFF = full scale |
| busy | output | 1 | A ramp is in progress |

## Verification
Immediate sets are due on the write edge itself, because the code register loads there and the level follows it through the table in the same cycle. Ramp steps are due at the start edge plus a whole multiple of step time × UNIT_CYCLES. The driver converts every command into expected items stamped with those exact cycle numbers. The monitor compares an item only in the falling-edge slot of its own cycle, and it also checks the cycle just before each due step, so a step that lands early or late fails. Items that pass their due cycle without being compared are reported as missed.

// File: rtl/dimSeqPkg.sv
package dimSeqPkg;

  localparam int CODE_W   = 5;
  localparam int LEVEL_W  = 16;
  localparam int SEL_W    = 4;
  localparam int CODE_CNT = 1 << CODE_W;

  localparam logic [SEL_W-1:0] SEL_DIRECT   = 4'h1;
  localparam logic [SEL_W-1:0] SEL_ARM_UP   = 4'h2;
  localparam logic [SEL_W-1:0] SEL_ARM_DOWN = 4'h3;
  localparam logic [SEL_W-1:0] SEL_START    = 4'h4;

  // 10^(-0.1) in Q24: ratio between neighbouring table entries
  localparam logic [63:0] STEP_RATIO_Q24 = 64'd13326616;

  typedef logic [CODE_CNT-1:0][LEVEL_W-1:0] levelRom_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic              load;
    logic              stepUp;
    logic              stepDown;
    logic [CODE_W-1:0] value;
  } stepCmd_t;

  // Table built at elaboration: top entry is full scale, each lower one
  // is 10^(-0.1) of its neighbour; entry 0 is forced to zero.
  function automatic levelRom_t buildLevelRom();
    levelRom_t   rom;
    logic [63:0] acc;
    acc = 64'((2 ** LEVEL_W) - 1) << 16;
    for (int n = CODE_CNT - 1; n >= 1; n--) begin
      rom[CODE_W'(n)] = LEVEL_W'((acc + 64'h8000) >> 16);
      acc = (acc * STEP_RATIO_Q24) >> 24;
    end
    rom[0] = '0;
    return rom;
  endfunction

  localparam levelRom_t LEVEL_ROM = buildLevelRom();

endpackage

// File: rtl/dimCtrl.sv
module dimCtrl
  import dimSeqPkg::*;
#(
  parameter int UNIT_CYCLES = 10000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [CODE_W-1:0] wrCode,
  input  logic [CODE_W-1:0] curCode,
  output stepCmd_t          cmd,
  output logic              busy
);

  localparam int PRE_W = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_CYCLES - 1);

  logic [CODE_W-1:0] armTarget, runTarget, stepTime, unitCnt;
  logic              armDown, runDown;
  logic [PRE_W-1:0]  preCnt;

  logic directWr, startWr, armUpWr, armDownWr;
  logic unitTick, stepDue, canUp, canDown;

  assign directWr  = wrEn && (wrSel == SEL_DIRECT);
  assign armUpWr   = wrEn && (wrSel == SEL_ARM_UP);
  assign armDownWr = wrEn && (wrSel == SEL_ARM_DOWN);
  assign startWr   = wrEn && (wrSel == SEL_START);

  // One pulse per 10 ms unit while a ramp runs (R5)
  assign unitTick = busy && (preCnt == PRE_LAST);
  assign stepDue  = unitTick && !directWr && !startWr &&
                    ((stepTime == '0) || (unitCnt == stepTime - 5'd1));

  assign canUp   = curCode < runTarget;
  assign canDown = curCode > runTarget;

  // Strobe generation: direct load (R2), jump (R7), single steps (R6, R8)
  always_comb begin
    cmd = '0;
    if (directWr) begin
      cmd.load  = 1'b1;
      cmd.value = wrCode;
    end else if (stepDue) begin
      if (stepTime == '0) begin
        if (runDown ? canDown : canUp) begin
          cmd.load  = 1'b1;
          cmd.value = runTarget;
        end
      end else if (!runDown && canUp) begin
        cmd.stepUp = 1'b1;
      end else if (runDown && canDown) begin
        cmd.stepDown = 1'b1;
      end
    end
  end

  // Armed target and direction (R1, R3)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armTarget <= '0;
      armDown   <= 1'b0;
    end else if (armUpWr) begin
      armTarget <= wrCode;
      armDown   <= 1'b0;
    end else if (armDownWr) begin
      armTarget <= wrCode;
      armDown   <= 1'b1;
    end
  end

  // Run state, prescaler and unit counter (R4, R5, R6, R7, R8)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      stepTime  <= '0;
      runTarget <= '0;
      runDown   <= 1'b0;
      preCnt    <= '0;
      unitCnt   <= '0;
    end else if (directWr) begin
      busy <= 1'b0;
    end else if (startWr) begin
      busy      <= 1'b1;
      stepTime  <= wrCode;
      runTarget <= armTarget;
      runDown   <= armDown;
      preCnt    <= '0;
      unitCnt   <= '0;
    end else if (busy) begin
      preCnt <= unitTick ? '0 : preCnt + 1'b1;
      if (unitTick) unitCnt <= stepDue ? '0 : unitCnt + 1'b1;
      if (stepDue) begin
        if (stepTime == '0)
          busy <= 1'b0;
        else if (runDown)
          busy <= canDown && ((curCode - 5'd1) != runTarget);
        else
          busy <= canUp && ((curCode + 5'd1) != runTarget);
      end
    end
  end

  // R6
  // stepping strobes only ever appear while a ramp is running
  step_needs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepUp || cmd.stepDown) |-> busy);

  // R2
  // a direct write leaves the sequencer idle
  direct_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    directWr |=> !busy);

  // R4
  // a start write leaves the sequencer running
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    startWr |=> busy);

endmodule

// File: rtl/dimDatapath.sv
module dimDatapath
  import dimSeqPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  stepCmd_t           cmd,
  output logic [CODE_W-1:0]  code,
  output logic [LEVEL_W-1:0] level
);

  // Code register (R1, R2, R6, R7)
  always_ff @(posedge clk) begin
    if (!rstN)             code <= '0;
    else if (cmd.load)     code <= cmd.value;
    else if (cmd.stepUp)   code <= code + 1'b1;
    else if (cmd.stepDown) code <= code - 1'b1;
  end

  // Logarithmic table lookup (R9)
  assign level = LEVEL_ROM[code];

  // R8
  // an upward step is never issued at the top code
  up_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.stepUp |-> (code != '1));

  // R8
  // a downward step is never issued at the bottom code
  down_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.stepDown |-> (code != '0));

  // R3
  // without a strobe the code holds
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.load || cmd.stepUp || cmd.stepDown) |=> $stable(code));

  // R9
  // the ends of the table are exact
  table_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((code == '1) |-> (level == '1)) and ((code == '0) |-> (level == '0)));

endmodule

// File: rtl/dimSequencer.sv
module dimSequencer
  import dimSeqPkg::*;
#(
  parameter int CLK_HZ  = 1_000_000,
  parameter int UNIT_MS = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [3:0]   wrSel,
  input  logic [7:0]   wrData,
  output logic [4:0]   ledCode,
  output logic [15:0]  ledLevel,
  output logic         busy
);

  localparam int UNIT_CYCLES = (CLK_HZ / 1000) * UNIT_MS;

  stepCmd_t cmd;

  // Reserved data bits take no part in any command (R2)
  logic unusedHiBits;
  assign unusedHiBits = ^wrData[7:CODE_W];

  dimCtrl #(.UNIT_CYCLES(UNIT_CYCLES)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrCode  (wrData[CODE_W-1:0]),
    .curCode (ledCode),
    .cmd     (cmd),
    .busy    (busy)
  );

  dimDatapath path_i (
    .clk   (clk),
    .rstN  (rstN),
    .cmd   (cmd),
    .code  (ledCode),
    .level (ledLevel)
  );

endmodule

// File: tb/dimSequencer_tb.sv
module dimSequencer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 1000;
  localparam int U          = 10;   // clock cycles per 10 ms unit at CLK_HZ

  logic       clk = 1'b0;
  logic       rstN;
  logic       wrEn;
  logic [3:0] wrSel;
  logic [7:0] wrData;
  logic [4:0] ledCode;
  logic [15:0] ledLevel;
  logic       busy;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  typedef struct {
    int         due;
    logic [4:0] code;
    bit         busy;
    string      req;
  } exp_t;

  exp_t q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dimSequencer #(.CLK_HZ(CLK_HZ), .UNIT_MS(10)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .ledCode(ledCode), .ledLevel(ledLevel), .busy(busy)
  );

  function automatic int expLevel(input int n);
    if (n == 0) return 0;
    return $rtoi(65535.0 * (10.0 ** ((n - 31) / 10.0)) + 0.5);
  endfunction

  task automatic pushExp(input int due, input logic [4:0] code, input bit b,
                         input string req);
    exp_t it;
    it.due = due; it.code = code; it.busy = b; it.req = req;
    q.push_back(it);
  endtask

  // Called at a falling edge: the write lands on the next rising edge,
  // whose cycle number is returned.
  task automatic wr(input logic [3:0] s, input logic [7:0] d, output int e);
    wrEn = 1'b1; wrSel = s; wrData = d;
    @(posedge clk);
    @(negedge clk);
    e = cyc;
    wrEn = 1'b0; wrSel = '0; wrData = '0;
  endtask

  task automatic waitUntil(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Monitor: compares each expected item in the slot of its due cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t it;
        int   lv;
        int   diff;
        it = q.pop_front();
        checks++;
        lv = expLevel(int'(it.code));
        diff = int'(ledLevel) - lv;
        if (it.due < cyc) begin
          errors++;
          $display("FAIL %s: missed at cycle %0d, actual none expected code=%0h",
                   it.req, it.due, it.code);
        end else if (ledCode !== it.code || busy !== it.busy || diff > 2 || diff < -2) begin
          errors++;
          $display("FAIL %s (R9 level) cycle %0d: actual code=%0h busy=%0b level=%0h expected code=%0h busy=%0b level=%0h",
                   it.req, cyc, ledCode, busy, ledLevel, it.code, it.busy, lv);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual cycle %0d expected end of run earlier", cyc);
    summary();
    $finish;
  end

  // Driver
  initial begin
    int e, f;
    rstN = 1'b0; wrEn = 1'b0; wrSel = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    pushExp(cyc, 5'h00, 0, "R1 reset state");

    // R1: nothing armed after reset
    wr(4'h4, 8'h01, e);
    pushExp(e, 5'h00, 1, "R4 start raises busy");
    pushExp(e + U, 5'h00, 0, "R1 zero armed target");
    waitUntil(e + U);

    // R10: other selects ignored
    wr(4'h5, 8'hFF, e);
    wr(4'h8, 8'h1F, e);
    wr(4'h0, 8'h1F, e);
    pushExp(e, 5'h00, 0, "R10 unused selects");

    // R2: direct set, high bits ignored
    wr(4'h1, 8'hEF, e);
    pushExp(e, 5'h0F, 0, "R2 direct set ignores bits 7:5");

    // R3 then R6 upward ramp, 10 ms steps
    wr(4'h2, 8'h12, e);
    pushExp(e, 5'h0F, 0, "R3 arming keeps code");
    wr(4'h4, 8'h01, e);
    pushExp(e + U - 1, 5'h0F, 1, "R5 no early step");
    pushExp(e + U, 5'h10, 1, "R6 up step 1");
    pushExp(e + 2 * U, 5'h11, 1, "R6 up step 2");
    pushExp(e + 3 * U, 5'h12, 0, "R6 up reaches target");
    waitUntil(e + 3 * U);

    // R5 downward, 30 ms steps
    wr(4'h3, 8'h10, e);
    wr(4'h4, 8'h03, e);
    pushExp(e + 3 * U - 1, 5'h12, 1, "R5 30ms no early step");
    pushExp(e + 3 * U, 5'h11, 1, "R5 30ms down step");
    pushExp(e + 6 * U, 5'h10, 0, "R6 down reaches target");
    waitUntil(e + 6 * U);

    // R5 high weight bit, 200 ms step
    wr(4'h2, 8'h11, e);
    wr(4'h4, 8'h14, e);
    pushExp(e + 20 * U - 1, 5'h10, 1, "R5 200ms no early step");
    pushExp(e + 20 * U, 5'h11, 0, "R5 200ms step");
    waitUntil(e + 20 * U);

    // R7 zero step time jumps
    wr(4'h2, 8'h1F, e);
    wr(4'h4, 8'h00, e);
    pushExp(e + U - 1, 5'h11, 1, "R7 no jump before unit");
    pushExp(e + U, 5'h1F, 0, "R7 jump to target");
    waitUntil(e + U);

    // R8 contradictory commands
    wr(4'h2, 8'h05, e);
    wr(4'h4, 8'h01, e);
    pushExp(e + U, 5'h1F, 0, "R8 up with lower target");
    waitUntil(e + U);
    wr(4'h2, 8'h1F, e);
    wr(4'h4, 8'h01, e);
    pushExp(e + U, 5'h1F, 0, "R8 up at top code");
    waitUntil(e + U);
    wr(4'h1, 8'h00, e);
    wr(4'h3, 8'h1F, e);
    wr(4'h4, 8'h01, e);
    pushExp(e + U, 5'h00, 0, "R8 down with higher target");
    waitUntil(e + U);

    // R4 restart mid ramp, R3 arming during ramp
    wr(4'h2, 8'h1F, e);
    wr(4'h4, 8'h01, e);
    pushExp(e + U, 5'h01, 1, "R6 ramp step 1");
    pushExp(e + 2 * U, 5'h02, 1, "R6 ramp step 2");
    waitUntil(e + 2 * U + 4);
    wr(4'h3, 8'h00, f);
    pushExp(f, 5'h02, 1, "R3 arm during ramp");
    pushExp(e + 3 * U, 5'h03, 1, "R3 ramp unaffected by arm");
    waitUntil(e + 3 * U + 1);
    wr(4'h4, 8'h01, f);
    pushExp(f + U - 1, 5'h03, 1, "R4 timing restarted");
    pushExp(f + U, 5'h02, 1, "R4 restart down step 1");
    pushExp(f + 2 * U, 5'h01, 1, "R4 restart down step 2");
    pushExp(f + 3 * U, 5'h00, 0, "R4 restart reaches target");
    waitUntil(f + 3 * U);

    // R2 direct set aborts ramp
    wr(4'h2, 8'h1F, e);
    wr(4'h4, 8'h01, e);
    waitUntil(e + U + 4);
    wr(4'h1, 8'h08, f);
    pushExp(f, 5'h08, 0, "R2 direct set aborts ramp");
    pushExp(e + 3 * U, 5'h08, 0, "R2 ramp stays abandoned");
    waitUntil(e + 3 * U);

    // R9 table points
    wr(4'h1, 8'h00, e); pushExp(e, 5'h00, 0, "R9 level code 00");
    wr(4'h1, 8'h01, e); pushExp(e, 5'h01, 0, "R9 level code 01");
    wr(4'h1, 8'h0F, e); pushExp(e, 5'h0F, 0, "R9 level code 0F");
    wr(4'h1, 8'h15, e); pushExp(e, 5'h15, 0, "R9 level code 15");
    wr(4'h1, 8'h1E, e); pushExp(e, 5'h1E, 0, "R9 level code 1E");
    wr(4'h1, 8'h1F, e); pushExp(e, 5'h1F, 0, "R9 level code 1F");

    waitUntil(cyc + 2);
    summary();
    $finish;
  end

endmodule